// File: doc/BRIEF.md
# Access-Checked Synchronous Memory Port

A small read-only word store that a slow external controller interrogates by placing an address on a set of general-purpose wires. Each clock edge captures the presented address and reads the matching word. The output pins then show the word only if the captured address lies in the permitted region. Otherwise they show zero and raise a denial flag.

The permission decision is made on the captured address, in the same stage as the captured word. The word and the verdict on it therefore always belong to one address. A controller that presents a protected address and switches to a permitted one before the result reaches the pins gets a denial for the protected read and then, one edge later, the permitted word. It never gets the protected word with the permitted verdict.

Top module: `guarded_rom_port`

## Requirements
- R1: The output reflects the address present at the most recent rising clock edge, so a new address shows its result one clock after it is applied.
- R2: The stored word at address a is ((a*29 + 17) mod 256) XOR 0xA5, with defaults of 6 address bits and 8 data bits.
- R3: An address is permitted when it is below PUB_COUNT (default 32). Addresses 0..31 are permitted and addresses 32..63 are protected.
- R4: For a permitted captured address, `rd_ok` is 1, `rd_denied` is 0 and `data_out` carries the stored word.
- R5: For a protected captured address, `data_out` is all zeros, `rd_denied` is 1 and `rd_ok` is 0.
- R6: The verdict applies to the captured address and never to the live address. After a protected address is captured and a permitted one is then applied, the protected word never appears on `data_out`.
- R7: During reset and until the first clock edge after reset is released, `data_out` is zero, `rd_denied` is 1 and `rd_ok` is 0. A reset in mid-run returns the port to this state.
- R8: Exactly one of `rd_ok` and `rd_denied` is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | Address driven by the external controller |
| data_out | output | DW | Released word, zero when the read is denied |
| rd_ok | output | 1 | High when the word on `data_out` is released |
| rd_denied | output | 1 | High when the last captured address was protected, or before the first read |

## Verification
The hardest case to reach is the race window. A protected address is captured, and the live address has already moved to a permitted value by the time the result is visible. The stimulus drives a protected address on one falling edge and checks the denied result on the next falling edge. In that same half-cycle it replaces the address with a permitted one, then checks that the following result is the permitted word and not the protected one. The boundary pair 31/32 and a reset in mid-run are also driven.

// File: rtl/guarded_rom_port.sv
module guarded_rom_port #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int PUB_COUNT = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  output logic [DW-1:0] data_out,
  output logic          rd_ok,
  output logic          rd_denied
);

  localparam int DEPTH = 1 << AW;

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    logic [DW+AW+5:0] t;
    t = ({{(DW+6){1'b0}}, a} * 29) + 17;
    return t[DW-1:0] ^ DW'(8'hA5);
  endfunction

  logic [DW-1:0] rom [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_rom
      assign rom[g] = rom_word(AW'(g));
    end
  endgenerate

  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_q;
  logic          live_q;
  logic          permit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      word_q <= '0;
      live_q <= 1'b0;
    end else begin
      addr_q <= addr_in;
      word_q <= rom[addr_in];
      live_q <= 1'b1;
    end
  end

  assign permit    = live_q && (int'(addr_q) < PUB_COUNT);
  assign data_out  = permit ? word_q : '0;
  assign rd_ok     = permit;
  assign rd_denied = !permit;

endmodule

module guarded_rom_port_chk #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int PUB_COUNT = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic [DW-1:0] data_out,
  input logic          rd_ok,
  input logic          rd_denied
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  p_one_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_ok, rd_denied}) == 1);

  p_denied_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_denied |-> data_out == '0);

  p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (rd_denied && data_out == '0));

  p_captured_protected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && int'($past(addr_in)) >= PUB_COUNT) |-> rd_denied);

  p_captured_public_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && int'($past(addr_in)) < PUB_COUNT) |-> rd_ok);

endmodule

bind guarded_rom_port guarded_rom_port_chk #(.AW(AW), .DW(DW), .PUB_COUNT(PUB_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
  .data_out(data_out), .rd_ok(rd_ok), .rd_denied(rd_denied)
);

// File: tb/test_guarded_rom_port.sv
module test_guarded_rom_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int PUB = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_out;
  logic          rd_ok, rd_denied;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  guarded_rom_port #(.AW(AW), .DW(DW), .PUB_COUNT(PUB)) i_guarded_rom_port (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .data_out(data_out), .rd_ok(rd_ok), .rd_denied(rd_denied)
  );

  function automatic logic [7:0] spec_word(input int a);
    return 8'(((a * 29) + 17) % 256) ^ 8'hA5;
  endfunction

  task automatic expect_out(input string req, input logic [7:0] wd, input logic ok);
    compared++;
    if (data_out !== wd || rd_ok !== ok || rd_denied !== !ok) begin
      mismatched++;
      $display("FAIL %s: data=%h ok=%b den=%b, expected data=%h ok=%b den=%b",
               req, data_out, rd_ok, rd_denied, wd, ok, !ok);
    end
  endtask

  task automatic expect_addr(input string req, input int a);
    if (a < PUB) expect_out(req, spec_word(a), 1'b1);
    else         expect_out(req, 8'h00, 1'b0);
  endtask

  task automatic t_reset;
    expect_out("R7 in reset", 8'h00, 1'b0);
    @(negedge clk);
    addr_in = 6'd5;
    rst_n = 1'b1;
    expect_out("R7 after release", 8'h00, 1'b0);
    @(negedge clk);
    expect_addr("R1 first read", 5);
  endtask

  task automatic t_sweep;
    for (int a = 0; a < (1 << AW); a++) begin
      addr_in = AW'(a);
      @(negedge clk);
      expect_addr(a < PUB ? "R2 R4 public" : "R3 R5 protected", a);
    end
  endtask

  task automatic t_boundary;
    addr_in = AW'(PUB - 1);
    @(negedge clk);
    expect_addr("R3 last public", PUB - 1);
    addr_in = AW'(PUB);
    @(negedge clk);
    expect_addr("R3 first protected", PUB);
  endtask

  task automatic t_race(input int prot, input int pub);
    addr_in = AW'(pub);
    @(negedge clk);
    addr_in = AW'(prot);
    @(negedge clk);
    expect_out("R6 protected captured", 8'h00, 1'b0);
    addr_in = AW'(pub);
    #1;
    expect_out("R6 live switch no leak", 8'h00, 1'b0);
    @(negedge clk);
    expect_out("R6 then public word", spec_word(pub), 1'b1);
    compared++;
    if (data_out === spec_word(prot)) begin
      mismatched++;
      $display("FAIL R6: data=%h, expected not %h", data_out, spec_word(prot));
    end
  endtask

  task automatic t_latency;
    addr_in = 6'd3;
    @(negedge clk);
    addr_in = 6'd9;
    #1;
    expect_addr("R1 holds old result", 3);
    @(negedge clk);
    expect_addr("R1 new result", 9);
  endtask

  task automatic t_midreset;
    addr_in = 6'd7;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    expect_out("R7 mid-run reset", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_addr("R7 after mid reset", 7);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_sweep();
    t_boundary();
    t_race(40, 12);
    t_race(63, 0);
    t_race(32, 31);
    t_latency();
    t_midreset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule